// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block watches a 10BASE-T receive path in normal-link-pulse mode and decides whether the segment can be trusted. Each received frame or link pulse restarts a loss counter driven by a millisecond tick. If the counter runs out, the link is declared down and the MAC loses permission to transmit. Idle link pulses are still requested while the link is down.

Recovery takes either one received frame, whatever its contents, or two link pulses whose spacing falls inside a window. The lower edge of that window is a short minimum gap and the upper edge is the loss interval. A pulse that arrives outside the window starts a new pair. A separate idle counter asks the line driver for a link pulse whenever no transmit activity has been seen for a set number of ticks.

Host control bits can do three things: bypass the link test for transmission, take over the link LED, and switch pulse generation off. All intervals are parameters counted in ticks.

Top module: `link_integrity_mon`

## Requirements
- R1: After reset, link_good is 0, tx_permit is 0 (with lt_disable clear), link_led_n is 1 (with led_ovr clear) and lp_req is 0.
- R2: Any cycle with rx_pkt or rx_lp high sets the count of ticks since receive activity to zero. It wins over an ms_tick in the same cycle. A link that is up stays up as long as no gap exceeds LOSS_MS ticks.
- R3: With the link up, the (LOSS_MS+1)-th consecutive ms_tick without receive activity takes the link down. link_good and tx_permit read 0 from the next cycle on.
- R4: While the link is down, one rx_pkt strobe brings link_good to 1 in the next cycle.
- R5: While the link is down, a single rx_lp never brings the link up. A second rx_lp, arriving g ticks after the first, brings it up in the next cycle exactly when GAP_MIN_MS < g <= LOSS_MS.
- R6: A second rx_lp outside the window counts as the first pulse of a new pair. Its own spacing to the next pulse decides recovery.
- R7: With led_ovr clear, link_led_n equals the inverse of link_good. With led_ovr set, link_led_n equals led_val. Both follow in the same cycle.
- R8: With lt_disable set, tx_permit is 1 whatever the link state, and link_good still reports the true state.
- R9: With nlp_en set, lp_req is a one-cycle pulse in the cycle after the IDLE_MS-th ms_tick since the last tx_act or the last request. It repeats every IDLE_MS ticks, and it is also produced while the link is down.
- R10: tx_act restarts the idle interval and takes priority over a tick in the same cycle. lp_req is 0 in the cycle after tx_act.
- R11: With nlp_en clear, lp_req stays 0 and the idle interval is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle millisecond timebase strobe |
| rx_pkt | input | 1 | One-cycle strobe: a frame was received |
| rx_lp | input | 1 | One-cycle strobe: a link pulse was received |
| tx_act | input | 1 | One-cycle strobe: a frame or pulse was transmitted |
| nlp_en | input | 1 | Enable idle link-pulse generation |
| lt_disable | input | 1 | Permit transmission regardless of link state |
| led_ovr | input | 1 | LED driven from led_val instead of link state |
| led_val | input | 1 | Host-chosen LED level used under override |
| link_good | output | 1 | 1 while the link is judged good |
| link_led_n | output | 1 | Active-low link LED |
| tx_permit | output | 1 | MAC may transmit frames |
| lp_req | output | 1 | One-cycle request to send a link pulse |

## Verification
The link state and lp_req are registered once, so they change one cycle after the strobe or tick that caused the change. tx_permit and link_led_n add no register after the link state, so they follow the control bits in the same cycle. The bench drives every input on the falling edge, holds a strobe for one cycle, and samples on the falling edge after the capturing rising edge. That sample point is exactly when a registered result is first visible. The gap sweep covers every spacing from zero to two ticks beyond the loss bound, and the idle sweep checks the request after each single tick.

// File: rtl/lim_pkg.sv
package lim_pkg;

    // Link supervisor state: down and waiting, down with one pulse seen, up.
    typedef enum logic [1:0] {
        LNK_DOWN  = 2'd0,
        LNK_ARMED = 2'd1,
        LNK_UP    = 2'd2
    } lnk_state_e;

endpackage

// File: rtl/lim_loss_timer.sv
module lim_loss_timer #(
    parameter int LOSS_MS = 50,
    parameter int LW      = $clog2(LOSS_MS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_tick,
    input  logic          rx_act,
    output logic [LW-1:0] elapsed,
    output logic          expire
);
    localparam logic [LW-1:0] LIMIT = LW'(LOSS_MS);
    localparam logic [LW-1:0] SAT   = LW'(LOSS_MS + 1);

    typedef struct packed {
        logic [LW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (rx_act) begin
            tmr_d.cnt = '0;
        end else if (ms_tick && (tmr_q.cnt != SAT)) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt <= SAT;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign elapsed = tmr_q.cnt;
    assign expire  = ms_tick && !rx_act && (tmr_q.cnt == LIMIT);

endmodule

// File: rtl/lim_link_fsm.sv
module lim_link_fsm
    import lim_pkg::*;
#(
    parameter int LOSS_MS    = 50,
    parameter int GAP_MIN_MS = 4,
    parameter int LW         = $clog2(LOSS_MS + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_pkt,
    input  logic          rx_lp,
    input  logic          expire,
    input  logic [LW-1:0] elapsed,
    output logic          link_up
);
    localparam logic [LW-1:0] LIMIT = LW'(LOSS_MS);
    localparam logic [LW-1:0] SAT   = LW'(LOSS_MS + 1);
    localparam logic [LW-1:0] GMIN  = LW'(GAP_MIN_MS);

    typedef struct packed {
        lnk_state_e st;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic in_window;

    assign in_window = (elapsed > GMIN) && (elapsed <= LIMIT);

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            LNK_UP: begin
                if (expire) fsm_d.st = LNK_DOWN;
            end
            LNK_DOWN: begin
                if (rx_pkt)     fsm_d.st = LNK_UP;
                else if (rx_lp) fsm_d.st = LNK_ARMED;
            end
            LNK_ARMED: begin
                if (rx_pkt) begin
                    fsm_d.st = LNK_UP;
                end else if (rx_lp) begin
                    // a pulse outside the window re-arms as a new first pulse
                    fsm_d.st = in_window ? LNK_UP : LNK_ARMED;
                end else if (elapsed == SAT) begin
                    fsm_d.st = LNK_DOWN;
                end
            end
            default: fsm_d.st = LNK_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q.st <= LNK_DOWN;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign link_up = (fsm_q.st == LNK_UP);

endmodule

// File: rtl/lim_pulse_gen.sv
module lim_pulse_gen #(
    parameter int IDLE_MS = 16,
    parameter int IW      = $clog2(IDLE_MS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic tx_act,
    input  logic nlp_en,
    output logic lp_req
);
    localparam logic [IW-1:0] LAST = IW'(IDLE_MS - 1);

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic          req;
    } pg_t;

    pg_t pg_d, pg_q;

    always_comb begin
        pg_d     = pg_q;
        pg_d.req = 1'b0;
        if (!nlp_en || tx_act) begin
            pg_d.cnt = '0;
        end else if (ms_tick) begin
            if (pg_q.cnt == LAST) begin
                pg_d.cnt = '0;
                pg_d.req = 1'b1;
            end else begin
                pg_d.cnt = pg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_q <= '0;
        end else begin
            pg_q <= pg_d;
        end
    end

    assign lp_req = pg_q.req;

endmodule

// File: rtl/link_integrity_mon.sv
module link_integrity_mon #(
    parameter int LOSS_MS    = 50,
    parameter int GAP_MIN_MS = 4,
    parameter int IDLE_MS    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic rx_pkt,
    input  logic rx_lp,
    input  logic tx_act,
    input  logic nlp_en,
    input  logic lt_disable,
    input  logic led_ovr,
    input  logic led_val,
    output logic link_good,
    output logic link_led_n,
    output logic tx_permit,
    output logic lp_req
);
    localparam int LW = $clog2(LOSS_MS + 2);
    localparam int IW = $clog2(IDLE_MS + 1);

    logic          rx_act;
    logic [LW-1:0] elapsed;
    logic          expire;
    logic          link_up;

    assign rx_act = rx_pkt | rx_lp;

    lim_loss_timer #(.LOSS_MS(LOSS_MS), .LW(LW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .rx_act  (rx_act),
        .elapsed (elapsed),
        .expire  (expire)
    );

    lim_link_fsm #(.LOSS_MS(LOSS_MS), .GAP_MIN_MS(GAP_MIN_MS), .LW(LW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_pkt  (rx_pkt),
        .rx_lp   (rx_lp),
        .expire  (expire),
        .elapsed (elapsed),
        .link_up (link_up)
    );

    lim_pulse_gen #(.IDLE_MS(IDLE_MS), .IW(IW)) u_pgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .ms_tick (ms_tick),
        .tx_act  (tx_act),
        .nlp_en  (nlp_en),
        .lp_req  (lp_req)
    );

    assign link_good  = link_up;
    assign tx_permit  = link_up | lt_disable;
    assign link_led_n = led_ovr ? led_val : ~link_up;

endmodule

// File: rtl/lim_checker.sv
module lim_checker #(
    parameter int LOSS_MS    = 50,
    parameter int GAP_MIN_MS = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick,
    input logic rx_pkt,
    input logic rx_lp,
    input logic tx_act,
    input logic nlp_en,
    input logic lt_disable,
    input logic led_ovr,
    input logic led_val,
    input logic link_good,
    input logic link_led_n,
    input logic tx_permit,
    input logic lp_req
);
    initial begin
        assert_param_window_R5: assert (GAP_MIN_MS < LOSS_MS);
    end

    // R3: the link only drops on a tick that carried no receive activity
    assert_drop_on_quiet_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_good) |-> ($past(ms_tick) && !$past(rx_pkt) && !$past(rx_lp)));

    // R4/R5: the link only comes up right after a frame or a link pulse
    assert_rise_needs_rx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_good) |-> ($past(rx_pkt) || $past(rx_lp)));

    assert_led_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!led_ovr |-> (link_led_n == !link_good)) and (led_ovr |-> (link_led_n == led_val)));

    assert_permit_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_good && !lt_disable) |-> !tx_permit);

    assert_permit_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lt_disable |-> tx_permit);

    assert_lp_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |=> !lp_req);

    assert_lp_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> ($past(ms_tick) && $past(nlp_en)));

    assert_tx_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_act |=> !lp_req);

    assert_lp_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !nlp_en |=> !lp_req);

endmodule

bind link_integrity_mon lim_checker #(.LOSS_MS(LOSS_MS), .GAP_MIN_MS(GAP_MIN_MS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ms_tick    (ms_tick),
    .rx_pkt     (rx_pkt),
    .rx_lp      (rx_lp),
    .tx_act     (tx_act),
    .nlp_en     (nlp_en),
    .lt_disable (lt_disable),
    .led_ovr    (led_ovr),
    .led_val    (led_val),
    .link_good  (link_good),
    .link_led_n (link_led_n),
    .tx_permit  (tx_permit),
    .lp_req     (lp_req)
);

// File: tb/link_integrity_mon_tb.sv
module link_integrity_mon_tb;
    localparam int LOSS = 6;
    localparam int GMIN = 2;
    localparam int IDLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0, rx_pkt = 1'b0, rx_lp = 1'b0, tx_act = 1'b0;
    logic nlp_en = 1'b0, lt_disable = 1'b0, led_ovr = 1'b0, led_val = 1'b0;
    logic link_good, link_led_n, tx_permit, lp_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    link_integrity_mon #(.LOSS_MS(LOSS), .GAP_MIN_MS(GMIN), .IDLE_MS(IDLE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .rx_pkt(rx_pkt), .rx_lp(rx_lp),
        .tx_act(tx_act), .nlp_en(nlp_en), .lt_disable(lt_disable), .led_ovr(led_ovr),
        .led_val(led_val), .link_good(link_good), .link_led_n(link_led_n),
        .tx_permit(tx_permit), .lp_req(lp_req)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic send_pkt();
        @(negedge clk) rx_pkt = 1'b1;
        @(negedge clk) rx_pkt = 1'b0;
    endtask

    task automatic send_lp();
        @(negedge clk) rx_lp = 1'b1;
        @(negedge clk) rx_lp = 1'b0;
    endtask

    task automatic send_tx();
        @(negedge clk) tx_act = 1'b1;
        @(negedge clk) tx_act = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 link_good", link_good, 1'b0);
        chk("R1 tx_permit", tx_permit, 1'b0);
        chk("R1 link_led_n", link_led_n, 1'b1);
        chk("R1 lp_req", lp_req, 1'b0);

        // R4 one frame recovers the link
        send_pkt();
        chk("R4 link_good", link_good, 1'b1);
        chk("R4 tx_permit", tx_permit, 1'b1);
        chk("R7 led low on good", link_led_n, 1'b0);

        // R2 activity restarts the loss count, also when coincident with a tick
        tick_n(LOSS);
        send_lp();
        tick_n(LOSS - 1);
        @(negedge clk) begin ms_tick = 1'b1; rx_pkt = 1'b1; end
        @(negedge clk) begin ms_tick = 1'b0; rx_pkt = 1'b0; end
        tick_n(LOSS);
        chk("R2 still good", link_good, 1'b1);
        send_pkt();

        // R3 loss sweep, R11 no pulse requests while nlp_en is clear
        for (int k = 1; k <= LOSS + 1; k++) begin
            tick_n(1);
            chk("R3 link_good", link_good, (k <= LOSS) ? 1'b1 : 1'b0);
            chk("R11 lp_req", lp_req, 1'b0);
        end
        chk("R3 tx_permit", tx_permit, 1'b0);
        chk("R7 led high on bad", link_led_n, 1'b1);

        // R5 pair spacing sweep
        for (int g = 0; g <= LOSS + 2; g++) begin
            tick_n(LOSS + 2);
            chk("R5 down before trial", link_good, 1'b0);
            send_lp();
            chk("R5 single pulse", link_good, 1'b0);
            tick_n(g);
            send_lp();
            chk("R5 pair gap", link_good, ((g > GMIN) && (g <= LOSS)) ? 1'b1 : 1'b0);
        end

        // R6 early second pulse becomes a new first pulse
        tick_n(LOSS + 2);
        send_lp();
        tick_n(1);
        send_lp();
        chk("R6 early pulse", link_good, 1'b0);
        tick_n(LOSS);
        send_lp();
        chk("R6 re-armed pair", link_good, 1'b1);

        // R4 frame while one pulse is pending
        tick_n(LOSS + 1);
        send_lp();
        send_pkt();
        chk("R4 frame while armed", link_good, 1'b1);
        tick_n(LOSS + 1);

        // R8 link-test bypass
        @(negedge clk) lt_disable = 1'b1;
        #1;
        chk("R8 tx_permit bypass", tx_permit, 1'b1);
        chk("R8 link_good true", link_good, 1'b0);
        @(negedge clk) lt_disable = 1'b0;
        #1;
        chk("R8 tx_permit restored", tx_permit, 1'b0);

        // R7 LED override
        for (int v = 0; v < 2; v++) begin
            @(negedge clk) begin led_ovr = 1'b1; led_val = v[0]; end
            #1;
            chk("R7 led override", link_led_n, v[0]);
        end
        @(negedge clk) led_ovr = 1'b0;

        // R9 periodic requests while the link is down
        @(negedge clk) nlp_en = 1'b1;
        send_tx();
        for (int j = 1; j <= 2 * IDLE; j++) begin
            tick_n(1);
            chk("R9 lp_req", lp_req, ((j % IDLE) == 0) ? 1'b1 : 1'b0);
            if ((j % IDLE) == 0) begin
                @(negedge clk);
                chk("R9 one cycle", lp_req, 1'b0);
            end
        end
        chk("R9 link still down", link_good, 1'b0);

        // R10 transmit activity restarts the idle interval
        for (int j = 1; j < IDLE; j++) begin
            tick_n(1);
            chk("R10 before restart", lp_req, 1'b0);
        end
        send_tx();
        for (int j = 1; j <= IDLE; j++) begin
            tick_n(1);
            chk("R10 after restart", lp_req, (j == IDLE) ? 1'b1 : 1'b0);
        end

        // R11 disabling holds the interval at zero
        tick_n(IDLE - 1);
        @(negedge clk) nlp_en = 1'b0;
        tick_n(IDLE);
        chk("R11 disabled", lp_req, 1'b0);
        @(negedge clk) nlp_en = 1'b1;
        for (int j = 1; j <= IDLE; j++) begin
            tick_n(1);
            chk("R11 fresh interval", lp_req, (j == IDLE) ? 1'b1 : 1'b0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule